// File: doc/BRIEF.md
# Block Transfer DMA Engine

This block moves a programmed run of fixed-size blocks between a host controller's data buffer and system memory, one 32-bit word at a time. Software programs a 64-bit start address as two 32-bit halves, selects the direction and whether the address advances, and then writes a start bit. The engine then streams `blk_count * blk_size` bytes. In the card-to-memory direction it takes words from the buffer and writes them to memory. In the memory-to-card direction it reads words from memory and hands them to the buffer.

Completion and error are flagged per direction in two status registers. Each status register has its own mask register, and unmasked flags drive a single interrupt line. Each direction can be aborted through its own bit in a reset register. The engine only accepts a start while the host's DMA-enable input is high; while that input is low the buffer belongs to programmed I/O.

The register port is a plain write strobe with a word index and a combinational read. The memory side is a request/ready word interface, and the buffer side is a pair of valid/ready word streams.

Top module: `blk_dma`

## Requirements
- R1: After reset the engine is idle. The control, completion and error registers read zero, `irq` is low, and neither memory nor buffer traffic is requested.
- R2: Writing 1 to bit 0 of the control register (index 1) starts a transfer only when `dma_enable` is high and the engine is idle. While the transfer runs, control bit 0 reads 1, and it returns to 0 by itself at the end. A start written while `dma_enable` is low changes nothing.
- R3: A start whose address low word has any of bits [3:0] set moves no data. Instead it sets the error flag of the selected direction in the error register (index 5): bit 17 for card-to-memory, bit 16 for memory-to-card.
- R4: With mode register (index 0) bit 16 set, the engine runs card-to-memory. It accepts words from `buf_in` and writes them in order to memory, `blk_count*blk_size/4` words in total, then sets bit 20 of the completion register (index 3). Bit 17 of that register always reads 0.
- R5: With mode bit 16 clear, the engine runs memory-to-card. It reads memory words and delivers them in order on `buf_out`, then sets completion bit 16.
- R6: Mode bit 0 set advances the memory address by 4 after each accepted word. Mode bit 0 clear keeps every access at the start address.
- R7: While `mem_req` is high and `mem_ready` is low, the request, address, write flag and write data hold steady.
- R8: A write to the completion or error register clears each flag whose bit is written 0 and keeps each flag whose bit is written 1.
- R9: `irq` is high when any completion or error flag is set and its bit in the matching mask register (completion mask at index 4, error mask at index 6) is 0.
- R10: Writing bit 9 of the reset register (index 2) aborts a running card-to-memory transfer and clears bits 20 and 17. Writing bit 8 does the same for the memory-to-card direction (bits 16 and 16). A reset bit for the direction that is not running leaves the transfer running.
- R11: A start with a total length of zero moves no data and sets the completion flag of the selected direction at once.
- R12: A start written while a transfer runs is ignored, including any new address loaded since the transfer began.
- R13: The address high register (index 8) drives `mem_addr[63:32]`, and the address low register (index 7) drives `mem_addr[31:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| dma_enable | input | 1 | Host DMA mode enable |
| blk_size | input | SIZE_W | Block size in bytes (multiple of 4) |
| blk_count | input | CNT_W | Number of blocks |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 64 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory accepts the request |
| mem_rdata | input | 32 | Memory read data, valid with mem_ready |
| buf_in_valid | input | 1 | Buffer word available (card-to-memory) |
| buf_in_data | input | 32 | Buffer word |
| buf_in_ready | output | 1 | Engine takes the buffer word |
| buf_out_valid | output | 1 | Word for the buffer (memory-to-card) |
| buf_out_data | output | 32 | Word for the buffer |
| buf_out_ready | input | 1 | Buffer takes the word |
| irq | output | 1 | Unmasked status pending |

## Verification
The bench builds the engine with its default widths: a 12-bit block size and a 32-bit block count. It drives small block sizes (4, 8 and 16 bytes) and counts of 0 to 5. This puts multi-block runs, the zero-length start and both aborts within a few dozen cycles, and a non-zero address high word exercises the upper address half. Memory ready and buffer valid/ready follow uneven periodic patterns, with an extra stall for the aborts, so stalls land in every state of the single holding word.

// File: rtl/blk_dma.sv
module blk_dma #(
  parameter int SIZE_W = 12,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [3:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              dma_enable,
  input  logic [SIZE_W-1:0] blk_size,
  input  logic [CNT_W-1:0]  blk_count,
  output logic              mem_req,
  output logic              mem_we,
  output logic [63:0]       mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ready,
  input  logic [31:0]       mem_rdata,
  input  logic              buf_in_valid,
  input  logic [31:0]       buf_in_data,
  output logic              buf_in_ready,
  output logic              buf_out_valid,
  output logic [31:0]       buf_out_data,
  input  logic              buf_out_ready,
  output logic              irq
);
  localparam int LEN_W = CNT_W + SIZE_W;
  localparam logic [3:0] A_MODE = 4'd0, A_CTL = 4'd1, A_RST = 4'd2, A_DONE = 4'd3,
                         A_DMSK = 4'd4, A_ERR = 4'd5, A_EMSK = 4'd6, A_ADRL = 4'd7,
                         A_ADRH = 4'd8;

  logic mode_rd, mode_inc, busy, dir_q, inc_q, have;
  logic done_rd, done_wr, err_rd, err_wr, dm_rd, dm_wr, em_rd, em_wr;
  logic [31:0] adr_lo, adr_hi, hold;
  logic [63:0] cur;
  logic [LEN_W-1:0] rem, total, nwords;

  logic wr_ctl, wr_rst, wr_done, wr_err;
  logic start_req, misal, start_ok, start_nil, start_bad;
  logic mem_hs, in_hs, out_hs, step, finish, rst_rd, rst_wr, abort;

  assign wr_ctl  = reg_we && reg_addr == A_CTL;
  assign wr_rst  = reg_we && reg_addr == A_RST;
  assign wr_done = reg_we && reg_addr == A_DONE;
  assign wr_err  = reg_we && reg_addr == A_ERR;

  assign total  = LEN_W'(blk_count) * LEN_W'(blk_size);
  assign nwords = total >> 2;

  assign start_req = wr_ctl && reg_wdata[0] && !busy && dma_enable;
  assign misal     = |adr_lo[3:0];
  assign start_ok  = start_req && !misal && nwords != '0;
  assign start_nil = start_req && !misal && nwords == '0;
  assign start_bad = start_req && misal;

  assign mem_hs = mem_req && mem_ready;
  assign in_hs  = buf_in_valid && buf_in_ready;
  assign out_hs = buf_out_valid && buf_out_ready;
  assign step   = dir_q ? mem_hs : out_hs;
  assign finish = step && rem == LEN_W'(1);
  assign rst_rd = wr_rst && reg_wdata[9];
  assign rst_wr = wr_rst && reg_wdata[8];
  assign abort  = busy && ((rst_rd && dir_q) || (rst_wr && !dir_q));

  assign mem_req       = busy && (dir_q ? have : !have);
  assign mem_we        = dir_q;
  assign mem_addr      = cur;
  assign mem_wdata     = hold;
  assign buf_in_ready  = busy && dir_q && !have;
  assign buf_out_valid = busy && !dir_q && have;
  assign buf_out_data  = hold;
  assign irq = (done_rd && !dm_rd) || (done_wr && !dm_wr) || (err_rd && !em_rd) || (err_wr && !em_wr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_rd <= 1'b0; mode_inc <= 1'b0; adr_lo <= '0; adr_hi <= '0;
      dm_rd <= 1'b0; dm_wr <= 1'b0; em_rd <= 1'b0; em_wr <= 1'b0;
    end else if (reg_we) begin
      case (reg_addr)
        A_MODE: begin mode_rd <= reg_wdata[16]; mode_inc <= reg_wdata[0]; end
        A_DMSK: begin dm_rd <= reg_wdata[20]; dm_wr <= reg_wdata[16]; end
        A_EMSK: begin em_rd <= reg_wdata[17]; em_wr <= reg_wdata[16]; end
        A_ADRL: adr_lo <= reg_wdata;
        A_ADRH: adr_hi <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; dir_q <= 1'b0; inc_q <= 1'b0; have <= 1'b0;
      hold <= '0; cur <= '0; rem <= '0;
    end else begin
      if (abort || finish) busy <= 1'b0;
      else if (start_ok) busy <= 1'b1;
      if (start_ok) begin
        dir_q <= mode_rd; inc_q <= mode_inc; cur <= {adr_hi, adr_lo}; rem <= nwords;
      end else begin
        if (mem_hs && inc_q) cur <= cur + 64'd4;
        if (step) rem <= rem - LEN_W'(1);
      end
      if (start_ok || abort) have <= 1'b0;
      else if (in_hs) begin have <= 1'b1; hold <= buf_in_data; end
      else if (mem_hs && !dir_q) begin have <= 1'b1; hold <= mem_rdata; end
      else if (mem_hs || out_hs) have <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_rd <= 1'b0; done_wr <= 1'b0; err_rd <= 1'b0; err_wr <= 1'b0;
    end else begin
      done_rd <= (done_rd && !(wr_done && !reg_wdata[20]) && !rst_rd)
               || (finish && dir_q && !abort) || (start_nil && mode_rd);
      done_wr <= (done_wr && !(wr_done && !reg_wdata[16]) && !rst_wr)
               || (finish && !dir_q && !abort) || (start_nil && !mode_rd);
      err_rd  <= (err_rd && !(wr_err && !reg_wdata[17]) && !rst_rd) || (start_bad && mode_rd);
      err_wr  <= (err_wr && !(wr_err && !reg_wdata[16]) && !rst_wr) || (start_bad && !mode_rd);
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_MODE: begin reg_rdata[16] = mode_rd; reg_rdata[0] = mode_inc; end
      A_CTL:  reg_rdata[0] = busy;
      A_DONE: begin reg_rdata[20] = done_rd; reg_rdata[16] = done_wr; end
      A_DMSK: begin reg_rdata[20] = dm_rd; reg_rdata[16] = dm_wr; end
      A_ERR:  begin reg_rdata[17] = err_rd; reg_rdata[16] = err_wr; end
      A_EMSK: begin reg_rdata[17] = em_rd; reg_rdata[16] = em_wr; end
      A_ADRL: reg_rdata = adr_lo;
      A_ADRH: reg_rdata = adr_hi;
      default: ;
    endcase
  end

  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready && !wr_rst) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata) && $stable(mem_we)));

  p_fixed_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ready && !inc_q) |=> $stable(mem_addr));

  p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ready && inc_q) |=> (mem_addr == $past(mem_addr) + 64'd4));

  p_misalign_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && reg_wdata[0] && dma_enable && !busy && misal)
      |=> (!busy && ($past(mode_rd) ? err_rd : err_wr)));

  p_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && !dma_enable && !busy) |=> !busy);
endmodule

// File: tb/blk_dma_test.sv
module blk_dma_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] A_MODE = 4'd0, A_CTL = 4'd1, A_RST = 4'd2, A_DONE = 4'd3,
                         A_DMSK = 4'd4, A_ERR = 4'd5, A_EMSK = 4'd6, A_ADRL = 4'd7,
                         A_ADRH = 4'd8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic dma_enable = 1'b1;
  logic [11:0] blk_size = '0;
  logic [31:0] blk_count = '0;
  logic mem_req, mem_we, mem_ready = 1'b0;
  logic [63:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic buf_in_valid = 1'b0, buf_in_ready;
  logic [31:0] buf_in_data = '0;
  logic buf_out_valid, buf_out_ready = 1'b0;
  logic [31:0] buf_out_data;
  logic irq;

  blk_dma uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .dma_enable(dma_enable), .blk_size(blk_size), .blk_count(blk_count),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata), .buf_in_valid(buf_in_valid),
    .buf_in_data(buf_in_data), .buf_in_ready(buf_in_ready), .buf_out_valid(buf_out_valid),
    .buf_out_data(buf_out_data), .buf_out_ready(buf_out_ready), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  assign mem_rdata = mem_addr[31:0] ^ 32'h5A5A_0000;

  int total = 0, bad = 0, cyc = 0;
  bit stall = 1'b0, mdl_busy = 1'b0, mdl_dir = 1'b0, mdl_inc = 1'b0;
  longint unsigned mdl_addr = 0;
  int mdl_rem = 0, src_k = 0, wcount = 0;
  logic [31:0] out_q[$];

  task automatic chk(input string tag, input longint unsigned act, input longint unsigned exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    mem_ready     = !stall && (cyc % 3 != 0);
    buf_out_ready = !stall && (cyc % 4 != 1);
    buf_in_valid  = !stall && (cyc % 5 != 2);
    buf_in_data   = 32'hC0DE_0000 + src_k;
    #1;
    if (rst_n) begin
      if (!mdl_busy) chk("R2 idle traffic", {mem_req, buf_in_ready, buf_out_valid}, 0);
      else begin
        if (mem_req && mem_ready) begin
          chk(mdl_inc ? "R4/R13 mem addr" : "R6 fixed addr", mem_addr, mdl_addr);
          chk("R4/R5 mem dir", mem_we, mdl_dir);
          if (mdl_dir) begin
            chk("R4 mem data order", mem_wdata, 32'hC0DE_0000 + wcount);
            wcount++; mdl_rem--;
          end else out_q.push_back(mem_addr[31:0] ^ 32'h5A5A_0000);
          if (mdl_inc) mdl_addr += 4;
        end
        if (buf_in_valid && buf_in_ready) src_k++;
        if (buf_out_valid && buf_out_ready) begin
          if (out_q.size() == 0) chk("R5 buffer word without read", 1, 0);
          else chk("R5 buffer data", buf_out_data, out_q.pop_front());
          mdl_rem--;
        end
        if (mdl_rem <= 0) mdl_busy = 1'b0;
      end
    end
  end

  task automatic wreg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rchk(input string tag, input logic [3:0] a, input logic [31:0] exp);
    @(negedge clk); reg_addr = a; #2;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic run_start(input bit dir, input bit inc, input longint unsigned addr,
                           input int size, input int count, input bit expect_run);
    wreg(A_MODE, {15'b0, dir, 15'b0, inc});
    wreg(A_ADRL, addr[31:0]);
    wreg(A_ADRH, addr[63:32]);
    blk_size = 12'(size); blk_count = count;
    mdl_dir = dir; mdl_inc = inc; mdl_addr = addr; mdl_rem = size * count / 4;
    src_k = 0; wcount = 0; out_q.delete();
    @(negedge clk); reg_we = 1'b1; reg_addr = A_CTL; reg_wdata = 32'h1;
    @(negedge clk); reg_we = 1'b0;
    if (expect_run) mdl_busy = 1'b1;
  endtask

  task automatic wait_idle(input string tag);
    int n = 0;
    while (mdl_busy && n < 5000) begin @(negedge clk); n++; end
    chk(tag, mdl_busy, 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rchk("R1 ctl", A_CTL, 0);
    rchk("R1 done", A_DONE, 0);
    rchk("R1 err", A_ERR, 0);
    chk("R1 irq", irq, 0);
    chk("R1 mem_req", mem_req, 0);

    // R4 + R13 card-to-memory, increment, 64-bit address
    run_start(1'b1, 1'b1, 64'h0000_0001_0000_1000, 16, 3, 1'b1);
    rchk("R2 ctl busy", A_CTL, 1);
    wait_idle("R4 finish");
    chk("R4 words", wcount, 12);
    rchk("R2 ctl self clear", A_CTL, 0);
    rchk("R4 done bit20, bit17 zero", A_DONE, 32'h0010_0000);
    rchk("R4 err", A_ERR, 0);
    chk("R9 irq unmasked", irq, 1);
    wreg(A_DMSK, 32'h0010_0000);
    chk("R9 irq masked", irq, 0);
    wreg(A_DMSK, 0);
    // R8 write-zero clear
    wreg(A_DONE, 32'h0010_0000);
    rchk("R8 keep on 1", A_DONE, 32'h0010_0000);
    wreg(A_DONE, 0);
    rchk("R8 clear on 0", A_DONE, 0);

    // R5 memory-to-card
    run_start(1'b0, 1'b1, 64'h2000, 8, 2, 1'b1);
    wait_idle("R5 finish");
    chk("R5 queue drained", out_q.size(), 0);
    rchk("R5 done bit16", A_DONE, 32'h0001_0000);
    wreg(A_DONE, 0);

    // R6 fixed address
    run_start(1'b1, 1'b0, 64'h3000, 4, 5, 1'b1);
    wait_idle("R6 finish");
    chk("R6 words", wcount, 5);
    wreg(A_DONE, 0);

    // R3 misaligned both directions
    run_start(1'b1, 1'b1, 64'h4008, 16, 2, 1'b0);
    rchk("R3 err rd bit17", A_ERR, 32'h0002_0000);
    run_start(1'b0, 1'b1, 64'h4004, 16, 2, 1'b0);
    rchk("R3 err both", A_ERR, 32'h0003_0000);
    rchk("R3 no done", A_DONE, 0);
    wreg(A_EMSK, 32'h0003_0000);
    chk("R9 err masked", irq, 0);
    wreg(A_EMSK, 32'h0002_0000);
    chk("R9 err wr unmasked", irq, 1);
    wreg(A_EMSK, 0);
    wreg(A_ERR, 0);

    // R2 start ignored while disabled
    dma_enable = 1'b0;
    run_start(1'b1, 1'b1, 64'h5000, 16, 2, 1'b0);
    rchk("R2 disabled ctl", A_CTL, 0);
    rchk("R2 disabled done", A_DONE, 0);
    rchk("R2 disabled err", A_ERR, 0);
    dma_enable = 1'b1;

    // R12 start while running
    run_start(1'b1, 1'b1, 64'h6000, 16, 4, 1'b1);
    wreg(A_ADRL, 32'h0000_9000);
    wreg(A_CTL, 1);
    wait_idle("R12 finish");
    chk("R12 words", wcount, 16);
    wreg(A_DONE, 0);

    // R11 zero length, leaves done bit20 set
    run_start(1'b1, 1'b1, 64'h7000, 16, 0, 1'b0);
    rchk("R11 done", A_DONE, 32'h0010_0000);

    // R10 abort card-to-memory
    run_start(1'b1, 1'b1, 64'h8000, 16, 4, 1'b1);
    stall = 1'b1;
    repeat (3) @(negedge clk);
    wreg(A_RST, 32'h0000_0100);
    rchk("R10 other channel keeps running", A_CTL, 1);
    rchk("R10 other channel keeps done", A_DONE, 32'h0010_0000);
    wreg(A_RST, 32'h0000_0200);
    mdl_busy = 1'b0; out_q.delete();
    rchk("R10 rd abort ctl", A_CTL, 0);
    rchk("R10 rd abort done", A_DONE, 0);
    stall = 1'b0;
    repeat (6) @(negedge clk);

    // R10 abort memory-to-card
    run_start(1'b0, 1'b1, 64'h9000, 16, 2, 1'b1);
    stall = 1'b1;
    repeat (3) @(negedge clk);
    wreg(A_RST, 32'h0000_0100);
    mdl_busy = 1'b0; out_q.delete();
    rchk("R10 wr abort ctl", A_CTL, 0);
    rchk("R10 wr abort done", A_DONE, 0);
    stall = 1'b0;
    repeat (6) @(negedge clk);

    // after aborts a new transfer completes
    run_start(1'b0, 1'b1, 64'h0000_0002_0000_A000, 16, 1, 1'b1);
    wait_idle("R5 after abort");
    rchk("R5 done after abort", A_DONE, 32'h0001_0000);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule